// File: doc/BRIEF.md
# Programmable Peripheral Clock-Enable Generator

This block turns one of three single-cycle source tick streams into a slower peripheral tick stream. The whole block runs on one fast system clock. Each source clock is a one-cycle strobe, and the derived clock is also a one-cycle enable pulse on `tick_o`. A control word sets the source selector and two cascaded divisors. A separate gate word turns the output on or off.

Software writes both words through a simple write strobe and can read them back at any time. A new control value does not act at once. It is staged, and the running divider picks it up only at the start of an output period. Because of this, a change made in the middle of a period never cuts a pulse short and never adds an extra pulse. When the gate is closed, only the output is held low. The two divider counters keep running, so the output phase is kept across the gated time.

Top module: `periph_clk_gen`

## Requirements
- R1: The selector sits in control bits [5:4]. Codes 0 and 1 both take `src_tick_i[0]` (I/O source), code 2 takes `src_tick_i[1]` (CPU source), and code 3 takes `src_tick_i[2]` (memory source). Ticks on sources that are not selected have no effect on `tick_o`.
- R2: The first divisor sits in control bits [13:8] and is one-based: a value of N passes one output tick for every N selected source ticks.
- R3: The second divisor sits in control bits [25:20]. It is also one-based and divides the output of the first divider, so the total ratio is d0*d1.
- R4: A divisor of zero acts exactly like a divisor of one. Any value from 0 to 63 keeps the divider running.
- R5: The gate is bit 0 of the word at byte offset 8. Writing 1 closes the gate and forces `tick_o` low. Writing 0 opens the gate.
- R6: While the gate is closed, both divider counters keep counting selected source ticks, so the output phase is the same as if the gate had stayed open.
- R7: While `rst_ni` is low, the control word clears to 0 and the gate takes the value of `~en_rst_i`, so the clock is on after reset exactly when `en_rst_i` is 1.
- R8: Reading offset 0 returns the stored selector and divisor fields, with all other bits 0. Reading offset 8 returns the gate in bit 0, with all other bits 0. Any other offset reads as 0.
- R9: A written control value takes effect only in a cycle where both counters are at zero and no selected tick arrives. A period that is already in progress completes with the old settings.
- R10: `tick_o` is high for one cycle, in the cycle after the clock edge that samples the selected source tick completing a d0*d1 period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_rst_i | input | 1 | Requested clock enable applied during reset |
| src_tick_i | input | 3 | Source tick strobes: [0] I/O, [1] CPU, [2] memory |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Byte offset: 0 is the control word, 8 is the gate word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| tick_o | output | 1 | Divided, gated output tick |

## Verification
An output tick is due one clock after the edge that samples the completing source tick. Register reads are combinational, and a control write is applied within two idle cycles when no period is in progress. The bench drives inputs and samples outputs on the falling edge. It leaves three idle cycles after the last tick of each window before it closes the window, and it waits two idle cycles after each control write before it sends ticks. A scoreboard compares each window's tick count with floor(ticks / (max(d0,1)*max(d1,1))). A separate check confirms the one-cycle latency directly.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int DIV_W    = 6;
  localparam int SEL_W    = 2;
  localparam int SEL_LO   = 4;
  localparam int D0_LO    = 8;
  localparam int D1_LO    = 20;
  localparam int GATE_OFS = 8;
  localparam int CTRL_OFS = 0;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] d0;
    logic [DIV_W-1:0] d1;
  } cfg_t;
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
  import pclk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_rst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output cfg_t              cfg_o,
  output logic              gate_o
);
  cfg_t cfg_q;
  logic gate_q;
  logic hit_ctrl, hit_gate;

  assign hit_ctrl = (addr_i == ADDR_W'(CTRL_OFS));
  assign hit_gate = (addr_i == ADDR_W'(GATE_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      gate_q <= ~en_rst_i;
    end else if (we_i) begin
      if (hit_ctrl) begin
        cfg_q.sel <= wdata_i[SEL_LO +: SEL_W];
        cfg_q.d0  <= wdata_i[D0_LO +: DIV_W];
        cfg_q.d1  <= wdata_i[D1_LO +: DIV_W];
      end
      if (hit_gate) gate_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[SEL_LO +: SEL_W] = cfg_q.sel;
      rdata_o[D0_LO +: DIV_W]  = cfg_q.d0;
      rdata_o[D1_LO +: DIV_W]  = cfg_q.d1;
    end else if (hit_gate) begin
      rdata_o[0] = gate_q;
    end
  end

  assign cfg_o  = cfg_q;
  assign gate_o = gate_q;

  // R5
  gate_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_gate) |=> (gate_q == $past(wdata_i[0])));
  // R8
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && hit_ctrl) |=> $stable(cfg_q));
endmodule

// File: rtl/pclk_src_sel.sv
module pclk_src_sel
  import pclk_pkg::*;
#(
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int N_CODE = 1 << SEL_W;
  logic [N_CODE-1:0] code_tick;

  // codes 0 and 1 both reach source 0; code k>=2 reaches source k-1
  for (genvar k = 0; k < N_CODE; k++) begin : g_code
    localparam int SRC = (k == 0) ? 0 : k - 1;
    assign code_tick[k] = src_i[SRC];
  end

  assign tick_o = code_tick[sel_i];
endmodule

// File: rtl/pclk_div.sv
module pclk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             idle_o
);
  logic [DIV_W-1:0] cnt_q, last;

  // zero acts as one
  assign last   = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = tick_i && (cnt_q == last);
  assign idle_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= last));
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/periph_clk_gen.sv
module periph_clk_gen
  import pclk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int N_SRC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_rst_i,
  input  logic [N_SRC-1:0]  src_tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              tick_o
);
  cfg_t cfg_sw, cfg_act;
  logic gate;
  logic sel_tick, t0, t1, idle0, idle1, load;
  logic tick_q;

  pclk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk_i, .rst_ni, .en_rst_i,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .cfg_o(cfg_sw), .gate_o(gate)
  );

  pclk_src_sel #(.N_SRC(N_SRC)) sel_i (
    .src_i(src_tick_i), .sel_i(cfg_act.sel), .tick_o(sel_tick)
  );

  pclk_div #(.DIV_W(DIV_W)) div0_i (
    .clk_i, .rst_ni, .tick_i(sel_tick), .div_i(cfg_act.d0),
    .tick_o(t0), .idle_o(idle0)
  );

  pclk_div #(.DIV_W(DIV_W)) div1_i (
    .clk_i, .rst_ni, .tick_i(t0), .div_i(cfg_act.d1),
    .tick_o(t1), .idle_o(idle1)
  );

  // period boundary: nothing counted, nothing arriving
  assign load = idle0 && idle1 && !sel_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_act <= '0;
      tick_q  <= 1'b0;
    end else begin
      if (load) cfg_act <= cfg_sw;
      tick_q <= t1 && !gate;
    end
  end

  assign tick_o = tick_q;

  // R5
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate |=> !tick_o);
  // R10
  tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(sel_tick));
  // R9
  cfg_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_act != $past(cfg_act)) |-> $past(idle0 && idle1));
  // R10
  tick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (cfg_act.d0 > 6'd1) |=> !tick_o);
endmodule

// File: tb/periph_clk_gen_tb_top.sv
module periph_clk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_rst = 1'b1;
  logic [2:0]  src = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick;

  int n_run = 0, n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  int live_cnt = 0;
  bit close_req = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  periph_clk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_rst_i(en_rst), .src_tick_i(src),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .tick_o(tick)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: counts ticks, pops expected count at window close
  initial forever begin
    @(negedge clk);
    if (tick) live_cnt++;
    if (close_req) begin
      check(tag_q.pop_front(), live_cnt, exp_q.pop_front());
      live_cnt  = 0;
      close_req = 1'b0;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0;
    idle(2);
  endtask

  task automatic rd_check(string tag, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, int'(rdata), int'(exp));
    addr = '0;
  endtask

  function automatic logic [31:0] ctrl(int sel, int d0, int d1);
    return (32'(sel) << 4) | (32'(d0) << 8) | (32'(d1) << 20);
  endfunction

  task automatic pulses(int s, int n, logic [2:0] noise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src = (3'b1 << s) | noise;
      @(negedge clk);
      src = noise & ~(3'b1 << s);
      @(negedge clk);
      src = '0;
    end
  endtask

  // driver: pushes expected count, then closes the window
  task automatic window(string tag, int s, int n, int exp, logic [2:0] noise);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    pulses(s, n, noise);
    idle(3);
    @(posedge clk);
    close_req = 1'b1;
    wait (close_req == 1'b0);
  endtask

  function automatic int ratio(int n, int d0, int d1);
    int e0 = (d0 == 0) ? 1 : d0;
    int e1 = (d1 == 0) ? 1 : d1;
    return n / (e0 * e1);
  endfunction

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R7 reset state with enable requested
    rd_check("R7 ctrl after reset", 4'd0, 32'h0);
    rd_check("R7 gate open after reset", 4'd8, 32'h0);
    // R4 R2 default zero divisors pass every tick
    window("R4 default pass-through", 0, 10, 10, 3'b000);
    // R10 latency
    @(negedge clk); src = 3'b001;
    @(negedge clk); src = 3'b000;
    check("R10 tick one cycle after source", int'(tick), 1);
    @(negedge clk);
    check("R10 single-cycle pulse", int'(tick), 0);
    live_cnt = 0;
    // R8 readback masks unused bits
    wr(4'd0, 32'hFFFF_FFFF);
    rd_check("R8 ctrl readback mask", 4'd0, 32'h03F0_3F30);
    rd_check("R8 unmapped offset", 4'd4, 32'h0);
    // R1 code 1 -> io, cpu/mem noise ignored
    wr(4'd0, ctrl(1, 3, 1));
    window("R1 code1 io, R2 d0=3", 0, 12, ratio(12, 3, 1), 3'b110);
    // R1 code 2 -> cpu
    wr(4'd0, ctrl(2, 2, 3));
    window("R1 code2 cpu, R3 2x3", 1, 12, ratio(12, 2, 3), 3'b101);
    // R1 code 3 -> mem, R4 d0 zero
    wr(4'd0, ctrl(3, 0, 4));
    window("R1 code3 mem, R4 d0=0", 2, 8, ratio(8, 0, 4), 3'b011);
    wr(4'd0, ctrl(3, 0, 0));
    window("R4 both zero", 2, 5, 5, 3'b000);
    // R1 unselected source alone
    window("R1 unselected source ignored", 0, 6, 0, 3'b000);
    // R3 large ratio
    wr(4'd0, ctrl(0, 63, 2));
    window("R3 63x2 partial", 0, 125, 0, 3'b000);
    window("R3 63x2 completes", 0, 1, 1, 3'b000);
    // R5 R6 gate with running counters
    wr(4'd0, ctrl(0, 3, 1));
    wr(4'd8, 32'h1);
    rd_check("R5 gate readback", 4'd8, 32'h1);
    window("R5 gated output low", 0, 4, 0, 3'b000);
    wr(4'd8, 32'h0);
    window("R6 phase kept across gate", 0, 2, 1, 3'b000);
    // R9 mid-period change finishes old period
    wr(4'd0, ctrl(0, 4, 1));
    pulses(0, 2, 3'b000);
    wr(4'd0, ctrl(0, 2, 1));
    window("R9 old period completes", 0, 2, 1, 3'b000);
    window("R9 new divisor active", 0, 4, 2, 3'b000);
    // R7 reset with enable not requested
    @(negedge clk); en_rst = 1'b0; rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    rd_check("R7 gate closed after reset", 4'd8, 32'h1);
    rd_check("R7 ctrl cleared", 4'd0, 32'h0);
    window("R7 clock off after reset", 0, 4, 0, 3'b000);
    wr(4'd8, 32'h0);
    window("R5 gate reopened", 0, 4, 4, 3'b000);
    report();
  end
endmodule